// File: doc/BRIEF.md
# I2C Controller Interrupt Vector Unit

This block sits beside an I2C controller core and turns the core's one-cycle event pulses into interrupt state that a CPU can read. There are seven events: arbitration lost, NACK, access ready, receive data ready, transmit ready, stop detected and addressed as slave. Each pulse sets a pending flag. A mask register decides which pending flags may raise the single level interrupt line. Each flag is cleared by its own mechanism. For the two flags that software clears by writing, the state is also visible in a status register.

A CPU handler reads one vector register. That register returns a small code naming the most urgent pending, enabled event. The read also acknowledges that event, so the handler can loop on the vector register until it returns zero. The status register also carries two live copies of core state, bus busy and receive shift full, which software can read but not change.

Top module: `i2c_evt_vector`

## Requirements
- R1: After reset every pending flag and every mask bit is clear, the vector register reads 0 and `irq` is low.
- R2: Pulse input bit i sets the pending flag of the event with vector code i+1: bit 0 arbitration lost (code 1), bit 1 NACK (2), bit 2 access ready (3), bit 3 receive data ready (4), bit 4 transmit ready (5), bit 5 stop detected (6), bit 6 addressed as slave (7). A flag is set whatever the mask holds.
- R3: The mask register at offset 0x04 holds one enable bit per event at bit i = code-1 (bits 0 to 6), reads back what was written, and reads 0 in bits 7 and above.
- R4: The vector register at offset 0x28 returns the lowest code whose event is both pending and enabled, or 0 when there is none. Arbitration lost therefore has the highest priority.
- R5: A read of the vector register clears, at that clock edge, the pending flag of the event it returns, so repeated reads return the enabled events in rising code order and then 0.
- R6: The status register at offset 0x08 shows arbitration lost at bit 0, NACK at bit 1, access ready at bit 2, stop detected at bit 5, the live receive-shift-full input at bit 11 and the live bus-busy input at bit 12. All other bits read 0.
- R7: Writing 1 to status bit 2 clears the access-ready flag and writing 1 to bit 5 clears the stop-detected flag. Writes to every other status bit, including bits 0, 1, 11 and 12, change nothing.
- R8: A pulse on `rx_data_read` clears the receive-data-ready flag.
- R9: `irq` is high exactly while at least one pending flag is also enabled in the mask.
- R10: When a flag is set by a pulse in the same cycle that a clear (vector read, status write or receive read) targets it, the flag stays set.
- R11: A pending flag whose mask bit is 0 is not reported by the vector register and does not raise `irq`. Once its mask bit is set, it is reported.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_pulse | input | 7 | One-cycle event pulses from the core, bit i = code i+1 |
| rx_data_read | input | 1 | Pulse: the receive data register was read |
| core_bus_busy | input | 1 | Live bus-busy state from the core |
| core_rxshift_full | input | 1 | Live receive-shift-full state from the core |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (needed for the vector read acknowledge) |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, combinational from the current address |
| irq | output | 1 | Level interrupt request |

## Verification
Two things can land in the same cycle: the acknowledge of a flag and a fresh pulse of the same event. The acknowledge can come from a vector read, a status write-one or a receive read. The bench provokes this by driving the clearing access and the pulse on the same clock edge. It then reads the flag back through the status or vector register. The collision passes only if the new event survives: the status bit is still set, or the vector read returns the same code a second time before it drains to 0.

// File: rtl/i2c_evt_pkg.sv
// Package: shared constants for the I2C interrupt vector unit.
// Assumes event index i corresponds to vector code i+1.
package i2c_evt_pkg;
    localparam int NUM_EVT = 7;
    localparam int CODE_W  = $clog2(NUM_EVT + 1);

    // Event indices (priority order, 0 is most urgent)
    localparam int EV_ARB   = 0;
    localparam int EV_NACK  = 1;
    localparam int EV_ACC   = 2;
    localparam int EV_RX    = 3;
    localparam int EV_TX    = 4;
    localparam int EV_STOP  = 5;
    localparam int EV_SLAVE = 6;

    // Register byte offsets
    localparam int OFS_MASK = 'h04;
    localparam int OFS_STAT = 'h08;
    localparam int OFS_VEC  = 'h28;

    // Status bit positions
    localparam int ST_ARB    = 0;
    localparam int ST_NACK   = 1;
    localparam int ST_ACC    = 2;
    localparam int ST_STOP   = 5;
    localparam int ST_RSFULL = 11;
    localparam int ST_BUSY   = 12;
endpackage

// File: rtl/evt_flag_bank.sv
// Module: evt_flag_bank
// One sticky pending flag per event. A set request wins over a clear
// request in the same cycle so that no new event is lost.
// Assumes set and clr are single-cycle requests from the same clock domain.
module evt_flag_bank #(
    parameter int N = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] pend
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        // Per-event flag: reset, set dominant, then clear
        always_ff @(posedge clk) begin
            if (!rst_n)      pend[i] <= 1'b0;
            else if (set[i]) pend[i] <= 1'b1;
            else if (clr[i]) pend[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/evt_prio_enc.sv
// Module: evt_prio_enc
// Fixed-priority encoder: lowest request index wins. Returns code index+1
// (0 when idle) and a one-hot grant used to acknowledge the winner.
// Assumes CW is wide enough to hold N.
module evt_prio_enc #(
    parameter int N  = 7,
    parameter int CW = $clog2(N + 1)
) (
    input  logic [N-1:0]  req,
    output logic [CW-1:0] code,
    output logic [N-1:0]  grant
);
    // Scan from lowest priority upward so the lowest index is left last
    always_comb begin
        code  = '0;
        grant = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                code     = CW'(i + 1);
                grant    = '0;
                grant[i] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/evt_regport.sv
// Module: evt_regport
// CPU-facing register decode: holds the mask register, forms clear
// requests (vector read acknowledge, status write-one, receive read),
// and multiplexes the read data.
// Assumes DATA_W >= 13 and that reg_rdata is sampled in the strobe cycle.
module evt_regport
    import i2c_evt_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16,
    parameter int N      = NUM_EVT,
    parameter int CW     = CODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic [N-1:0]      pend,
    input  logic [N-1:0]      grant,
    input  logic [CW-1:0]     code,
    input  logic              rx_data_read,
    input  logic              core_bus_busy,
    input  logic              core_rxshift_full,
    output logic [N-1:0]      mask,
    output logic [N-1:0]      clr,
    output logic [DATA_W-1:0] reg_rdata
);
    logic hit_mask, hit_stat, hit_vec;
    logic [DATA_W-1:0] stat_view;

    // Address decode
    always_comb begin
        hit_mask = (reg_addr == ADDR_W'(OFS_MASK));
        hit_stat = (reg_addr == ADDR_W'(OFS_STAT));
        hit_vec  = (reg_addr == ADDR_W'(OFS_VEC));
    end

    // Mask register storage
    always_ff @(posedge clk) begin
        if (!rst_n)                 mask <= '0;
        else if (reg_wr && hit_mask) mask <= reg_wdata[N-1:0];
    end

    // Clear requests toward the flag bank
    always_comb begin
        clr = '0;
        if (reg_rd && hit_vec) clr = grant;
        if (reg_wr && hit_stat) begin
            clr[EV_ACC]  = clr[EV_ACC]  | reg_wdata[ST_ACC];
            clr[EV_STOP] = clr[EV_STOP] | reg_wdata[ST_STOP];
        end
        clr[EV_RX] = clr[EV_RX] | rx_data_read;
    end

    // Status register view
    always_comb begin
        stat_view            = '0;
        stat_view[ST_ARB]    = pend[EV_ARB];
        stat_view[ST_NACK]   = pend[EV_NACK];
        stat_view[ST_ACC]    = pend[EV_ACC];
        stat_view[ST_STOP]   = pend[EV_STOP];
        stat_view[ST_RSFULL] = core_rxshift_full;
        stat_view[ST_BUSY]   = core_bus_busy;
    end

    // Read data multiplexer
    always_comb begin
        if (hit_mask)      reg_rdata = DATA_W'(mask);
        else if (hit_stat) reg_rdata = stat_view;
        else if (hit_vec)  reg_rdata = DATA_W'(code);
        else               reg_rdata = '0;
    end
endmodule

// File: rtl/i2c_evt_vector.sv
// Module: i2c_evt_vector (top)
// Collects I2C core event pulses into pending flags, gates them with a
// mask, encodes the most urgent one as a vector code that is acknowledged
// by reading it, and drives one level interrupt line.
// Assumes all inputs are synchronous to clk; reset is synchronous, active low.
module i2c_evt_vector
    import i2c_evt_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EVT-1:0] evt_pulse,
    input  logic               rx_data_read,
    input  logic               core_bus_busy,
    input  logic               core_rxshift_full,
    input  logic               reg_wr,
    input  logic               reg_rd,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    output logic               irq
);
    logic [NUM_EVT-1:0] pend, mask, clr, grant;
    logic [CODE_W-1:0]  vec_code;

    evt_flag_bank #(.N(NUM_EVT)) u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (evt_pulse),
        .clr   (clr),
        .pend  (pend)
    );

    evt_prio_enc #(.N(NUM_EVT), .CW(CODE_W)) u_enc (
        .req   (pend & mask),
        .code  (vec_code),
        .grant (grant)
    );

    evt_regport #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .N(NUM_EVT), .CW(CODE_W)) u_regs (
        .clk               (clk),
        .rst_n             (rst_n),
        .reg_wr            (reg_wr),
        .reg_rd            (reg_rd),
        .reg_addr          (reg_addr),
        .reg_wdata         (reg_wdata),
        .pend              (pend),
        .grant             (grant),
        .code              (vec_code),
        .rx_data_read      (rx_data_read),
        .core_bus_busy     (core_bus_busy),
        .core_rxshift_full (core_rxshift_full),
        .mask              (mask),
        .clr               (clr),
        .reg_rdata         (reg_rdata)
    );

    // Interrupt line: any enabled pending event
    always_comb irq = |(pend & mask);
endmodule

// File: rtl/i2c_evt_vector_chk.sv
// Module: i2c_evt_vector_chk
// Assertion checker bound to i2c_evt_vector; observes ports and the
// internal flag, mask and code signals.
module i2c_evt_vector_chk
    import i2c_evt_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_EVT-1:0] evt_pulse,
    input logic               core_bus_busy,
    input logic               core_rxshift_full,
    input logic               reg_wr,
    input logic               reg_rd,
    input logic [ADDR_W-1:0]  reg_addr,
    input logic [DATA_W-1:0]  reg_wdata,
    input logic [DATA_W-1:0]  reg_rdata,
    input logic               irq,
    input logic [NUM_EVT-1:0] pend,
    input logic [NUM_EVT-1:0] mask,
    input logic [CODE_W-1:0]  vec_code
);
    // R2 / R10: a pulse always leaves its flag set, whatever clears collide
    assert_pulse_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_pulse) |=> ((pend & $past(evt_pulse)) == $past(evt_pulse)));

    // R9: interrupt line agrees with the encoder's view
    assert_irq_vs_code_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (vec_code != '0));

    // R4: reported code is enabled, pending and has no more urgent rival
    assert_priority_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_code != '0) |->
            (pend[vec_code - 1'b1] && mask[vec_code - 1'b1] &&
             (((pend & mask) & ((NUM_EVT'(1) << (vec_code - 1'b1)) - NUM_EVT'(1))) == '0)));

    // R5: a vector read drops the flag it names unless re-pulsed
    assert_vec_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == ADDR_W'(OFS_VEC) && vec_code != '0 &&
         !evt_pulse[vec_code - 1'b1]) |=> !pend[$past(vec_code) - 1'b1]);

    // R3: mask write takes the low event bits
    assert_mask_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADDR_W'(OFS_MASK)) |=> (mask == $past(reg_wdata[NUM_EVT-1:0])));

    // R6: live core bits appear in the status readback
    assert_status_live_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == ADDR_W'(OFS_STAT)) |->
            (reg_rdata[ST_BUSY] == core_bus_busy && reg_rdata[ST_RSFULL] == core_rxshift_full));
endmodule

bind i2c_evt_vector i2c_evt_vector_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk               (clk),
    .rst_n             (rst_n),
    .evt_pulse         (evt_pulse),
    .core_bus_busy     (core_bus_busy),
    .core_rxshift_full (core_rxshift_full),
    .reg_wr            (reg_wr),
    .reg_rd            (reg_rd),
    .reg_addr          (reg_addr),
    .reg_wdata         (reg_wdata),
    .reg_rdata         (reg_rdata),
    .irq               (irq),
    .pend              (pend),
    .mask              (mask),
    .vec_code          (vec_code)
);

// File: tb/tb_i2c_evt_vector.sv
`timescale 1ns/1ps
// Directed bench for i2c_evt_vector: one task per scenario.
module tb_i2c_evt_vector;
    localparam logic [7:0] A_MASK = 8'h04;
    localparam logic [7:0] A_STAT = 8'h08;
    localparam logic [7:0] A_VEC  = 8'h28;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  evt_pulse = '0;
    logic        rx_data_read = 1'b0;
    logic        core_bus_busy = 1'b0;
    logic        core_rxshift_full = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        irq;

    int n_cmp = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    i2c_evt_vector dut (
        .clk               (clk),
        .rst_n             (rst_n),
        .evt_pulse         (evt_pulse),
        .rx_data_read      (rx_data_read),
        .core_bus_busy     (core_bus_busy),
        .core_rxshift_full (core_rxshift_full),
        .reg_wr            (reg_wr),
        .reg_rd            (reg_rd),
        .reg_addr          (reg_addr),
        .reg_wdata         (reg_wdata),
        .reg_rdata         (reg_rdata),
        .irq               (irq)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [15:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(posedge clk); #1;
        reg_rd = 1'b0;
    endtask

    task automatic pulse(input logic [6:0] v);
        @(negedge clk);
        evt_pulse = v;
        @(posedge clk); #1;
        evt_pulse = '0;
    endtask

    task automatic check_irq(input string req, input logic exp);
        @(negedge clk);
        check(req, {15'd0, irq}, {15'd0, exp});
    endtask

    task automatic t_reset;
        logic [15:0] d;
        check_irq("R1 irq", 1'b0);
        rd(A_VEC, d);  check("R1 vector", d, 16'h0000);
        rd(A_MASK, d); check("R1 mask", d, 16'h0000);
        rd(A_STAT, d); check("R1 status", d, 16'h0000);
    endtask

    task automatic t_mask_rw;
        logic [15:0] d;
        wr(A_MASK, 16'hFFFF);
        rd(A_MASK, d); check("R3 mask width", d, 16'h007F);
        wr(A_MASK, 16'h0015);
        rd(A_MASK, d); check("R3 mask pattern", d, 16'h0015);
    endtask

    task automatic t_priority;
        logic [15:0] d;
        wr(A_MASK, 16'h007F);
        pulse(7'h7F);
        check_irq("R9 irq on", 1'b1);
        rd(A_STAT, d); check("R6 status all", d, 16'h0027);
        for (int k = 1; k <= 7; k++) begin
            rd(A_VEC, d); check("R4 R5 drain order", d, 16'(k));
        end
        rd(A_VEC, d); check("R5 drained", d, 16'h0000);
        check_irq("R9 irq off", 1'b0);
        pulse(7'b0010000);
        rd(A_VEC, d); check("R2 tx ready code", d, 16'h0005);
    endtask

    task automatic t_masked;
        logic [15:0] d;
        wr(A_MASK, 16'h0000);
        pulse(7'b0100010);
        check_irq("R11 irq masked", 1'b0);
        rd(A_VEC, d);  check("R11 vector masked", d, 16'h0000);
        rd(A_STAT, d); check("R2 R6 flags set while masked", d, 16'h0022);
        wr(A_MASK, 16'h0020);
        check_irq("R11 irq enabled", 1'b1);
        rd(A_VEC, d);  check("R11 stop reported", d, 16'h0006);
        rd(A_VEC, d);  check("R11 nack still masked", d, 16'h0000);
        rd(A_STAT, d); check("R11 nack still pending", d, 16'h0002);
        wr(A_MASK, 16'h007F);
        rd(A_VEC, d);  check("R11 nack reported", d, 16'h0002);
        rd(A_VEC, d);  check("R5 empty", d, 16'h0000);
    endtask

    task automatic t_status;
        logic [15:0] d;
        @(negedge clk);
        core_bus_busy = 1'b1; core_rxshift_full = 1'b1;
        pulse(7'b0100111);
        rd(A_STAT, d); check("R6 status live and flags", d, 16'h1827);
        wr(A_STAT, 16'hFFFF);
        rd(A_STAT, d); check("R7 write-one clears only bits 2 and 5", d, 16'h1803);
        rd(A_VEC, d);  check("R7 arb lost kept", d, 16'h0001);
        rd(A_VEC, d);  check("R7 nack kept", d, 16'h0002);
        rd(A_VEC, d);  check("R7 nothing else", d, 16'h0000);
        @(negedge clk);
        core_bus_busy = 1'b0; core_rxshift_full = 1'b0;
        rd(A_STAT, d); check("R6 live bits follow", d, 16'h0000);
    endtask

    task automatic t_rx_clear;
        logic [15:0] d;
        pulse(7'b0001000);
        check_irq("R8 irq rx pending", 1'b1);
        @(negedge clk);
        rx_data_read = 1'b1;
        @(posedge clk); #1;
        rx_data_read = 1'b0;
        check_irq("R8 irq after data read", 1'b0);
        rd(A_VEC, d); check("R8 vector after data read", d, 16'h0000);
    endtask

    task automatic t_collide;
        logic [15:0] d;
        pulse(7'b0100000);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = A_STAT; reg_wdata = 16'h0020;
        evt_pulse = 7'b0100000;
        @(posedge clk); #1;
        reg_wr = 1'b0; evt_pulse = '0;
        rd(A_STAT, d); check("R10 stop survives write-one", d, 16'h0020);
        wr(A_STAT, 16'h0020);
        rd(A_STAT, d); check("R7 stop cleared", d, 16'h0000);
        pulse(7'b0000100);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = A_VEC; evt_pulse = 7'b0000100;
        #1 d = reg_rdata;
        @(posedge clk); #1;
        reg_rd = 1'b0; evt_pulse = '0;
        check("R4 access ready code", d, 16'h0003);
        rd(A_VEC, d); check("R10 access ready survives ack", d, 16'h0003);
        rd(A_VEC, d); check("R5 drained after collision", d, 16'h0000);
        pulse(7'b0001000);
        @(negedge clk);
        rx_data_read = 1'b1; evt_pulse = 7'b0001000;
        @(posedge clk); #1;
        rx_data_read = 1'b0; evt_pulse = '0;
        rd(A_VEC, d); check("R10 rx survives data read", d, 16'h0004);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_mask_rw();
        t_priority();
        t_masked();
        t_status();
        t_rx_clear();
        t_collide();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
            $finish;
        end
    end
endmodule